// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block sequences the commands that let a microcontroller rewrite its own program flash. Software arms an operation by writing a control/status byte with the enable bit set and a single command bit. It then fires a program strobe with an address and a data operand. The strobe is honoured only if it lands inside a short window after the arming write. Otherwise the arming lapses and the enable bit drops. The commands are page erase, word write, lock-bit programming, and re-enabling the read-while-write (RWW) region. A lock-byte read is an armed program-memory load at word address 1.

Erase and write run for a parameterised number of cycles. While they run, and afterwards until software re-enables it, the low RWW region of the flash is blocked. Loads from that region return a fixed filler word and set a sticky violation flag. Loads from the region above it are served normally. The interrupt request is a level: it is high whenever the interrupt enable is set and no command is armed or running. An EEPROM write in progress, signalled on a dedicated input, freezes the control byte, masks program strobes and refuses lock-byte reads. A flop-based flash stub and a six-bit lock register stand in for the real memory.

The controller has four named states:
- `ST_IDLE`: nothing armed.
- `ST_ARMED`: the window is open.
- `ST_ERASING`: a page erase is running.
- `ST_WRITING`: a word write is running.

The transitions are:
- `ST_IDLE` to `ST_ARMED` on an accepted write with the enable bit set.
- `ST_ARMED` to `ST_ERASING` or `ST_WRITING` on a strobe with the erase or write command.
- `ST_ARMED` to `ST_IDLE` on any of:
  - a strobe with the lock, re-enable or an invalid command;
  - a lock-byte load;
  - a write with the enable bit clear;
  - window expiry.
- `ST_ARMED` to `ST_ARMED`, re-armed, on a new write with the enable bit set.
- `ST_ERASING` or `ST_WRITING` to `ST_IDLE` when the operation timer reaches its count.

Top module: `fsp_ctrl`

## Requirements
- R1: After a control write with bit 0 set is sampled at clock edge t, a program strobe sampled at edges t+1 to t+WINDOW (default 4) dispatches the command. Without one, the enable bit and command bits read back zero after edge t+WINDOW, and a later strobe does nothing.
- R2: The control byte reads back as follows: bit 0 is enable (high in every state but idle), bits 4:1 are the armed command, bit 5 reads zero, bit 6 is the RWW busy flag and bit 7 is the interrupt enable. Out of reset it reads 0x00. The command values are bit 1 for page erase, bit 2 for word write, bit 3 for lock set and bit 4 for RWW re-enable.
- R3: A page erase sets every word of the addressed PAGE_WORDS-aligned page to all ones. A word write stores the data operand at the address. Each takes effect OP_CYCLES edges after dispatch, and no other word changes.
- R4: The busy flag (bit 6) rises at dispatch of erase or write and stays high after completion. It falls only when a re-enable command (value 0x11, bit 7 free) is strobed.
- R5: While busy, a load from a word address below RWW_WORDS returns 0xAAAA one cycle later and sets the violation flag, which stays set until reset. Loads at or above RWW_WORDS return the flash contents.
- R6: The interrupt request equals interrupt enable AND NOT enable bit, held as a level on every cycle.
- R7: A strobed lock-set command (value X0001001, bit 7 free) programs, in one edge, every lock bit whose matching data operand bit in 5:0 is zero. It leaves the busy flag low, and flash stays readable during it.
- R8: The lock bits reset to all ones, and no command ever returns a programmed (zero) lock bit to one.
- R9: With the lock-set command armed, a load from word address 1 returns {2'b11, lock bits} zero-extended and ends the arming. A load from any other address returns flash data and leaves the arming in place.
- R10: While the EEPROM-busy input is high, control writes are ignored, strobes dispatch nothing, and an armed lock-byte load returns flash data instead.
- R11: A strobe while the armed command field is zero or has more than one bit set is discarded: no flash change, busy unchanged, enable cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Control byte write strobe |
| csr_wdata | input | 8 | Control byte write value |
| csr_rdata | output | 8 | Control byte read value |
| prog_strobe | input | 1 | Program-memory store strobe |
| prog_addr | input | ADDR_W | Word address for erase/write |
| prog_data | input | DATA_W | Data operand (write word or lock mask) |
| load_req | input | 1 | Program-memory load request |
| load_addr | input | ADDR_W | Load word address |
| load_data | output | DATA_W | Load result, valid with load_vld |
| load_vld | output | 1 | Load result valid, one cycle after load_req |
| ee_busy | input | 1 | EEPROM write in progress |
| irq | output | 1 | Completion interrupt request (level) |
| viol | output | 1 | Sticky blocked-region access flag |

## Verification
The checker watches, on every cycle, that:
- the interrupt line tracks the enable and interrupt-enable bits;
- the busy flag is high through every running erase or write, and falls only after a strobed re-enable command;
- the control byte is frozen by an EEPROM-busy write;
- the lock bits never revert and the violation flag never clears.

Only the bench scenarios show the data-path outcomes:
- the exact window boundary, swept over strobe delays;
- erase and write contents, swept over the whole array;
- filler returns and lock byte values after a sequence of masks;
- the refused lock read under EEPROM busy;
- invalid command combinations.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_ERASING,
        ST_WRITING
    } fsp_state_e;

    // Control byte bit positions (software-visible, fixed)
    localparam int CSR_EN    = 0;
    localparam int CSR_CMD0  = 1;
    localparam int CSR_BUSY  = 6;
    localparam int CSR_IRQEN = 7;

    // Command field values (control bits 4:1)
    localparam logic [3:0] CMD_ERASE = 4'b0001;
    localparam logic [3:0] CMD_WRITE = 4'b0010;
    localparam logic [3:0] CMD_LOCK  = 4'b0100;
    localparam logic [3:0] CMD_RWWRE = 4'b1000;

    localparam int LOCK_W = 6;

endpackage

// File: rtl/fsp_fsm.sv
module fsp_fsm
    import fsp_pkg::*;
#(
    parameter int WINDOW    = 4,
    parameter int OP_CYCLES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csr_wr,
    input  logic [7:0] csr_wdata,
    input  logic       prog_strobe,
    input  logic       load_req,
    input  logic       lock_ptr,
    input  logic       ee_busy,
    output fsp_state_e state_o,
    output logic [3:0] cmd_o,
    output logic       irq_en_o,
    output logic       rww_busy_o,
    output logic       start_o,
    output logic       commit_erase_o,
    output logic       commit_write_o,
    output logic       lock_set_o,
    output logic       lock_rd_o
);

    localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam int TW = $clog2(OP_CYCLES + 1);
    localparam logic [CW-1:0] WIN_LAST = CW'(WINDOW - 1);
    localparam logic [TW-1:0] OP_LAST  = TW'(OP_CYCLES - 1);

    fsp_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic [3:0]    cmd_q, cmd_d;
    logic          irq_en_q, irq_en_d;
    logic          busy_q, busy_d;
    logic          csr_take;

    logic unused_wbits;
    assign unused_wbits = ^csr_wdata[6:5];

    assign csr_take = csr_wr && !ee_busy;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            tmr_q    <= '0;
            cmd_q    <= '0;
            irq_en_q <= 1'b0;
            busy_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            tmr_q    <= tmr_d;
            cmd_q    <= cmd_d;
            irq_en_q <= irq_en_d;
            busy_q   <= busy_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d        = state_q;
        cnt_d          = cnt_q;
        tmr_d          = tmr_q;
        cmd_d          = cmd_q;
        irq_en_d       = irq_en_q;
        busy_d         = busy_q;
        start_o        = 1'b0;
        commit_erase_o = 1'b0;
        commit_write_o = 1'b0;
        lock_set_o     = 1'b0;
        lock_rd_o      = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (csr_take) begin
                    irq_en_d = csr_wdata[CSR_IRQEN];
                    if (csr_wdata[CSR_EN]) begin
                        state_d = ST_ARMED;
                        cmd_d   = csr_wdata[CSR_CMD0 +: 4];
                        cnt_d   = '0;
                    end
                end
            end
            ST_ARMED: begin
                if (prog_strobe && !ee_busy) begin
                    state_d = ST_IDLE;
                    cmd_d   = '0;
                    unique case (cmd_q)
                        CMD_ERASE: begin
                            state_d = ST_ERASING;
                            cmd_d   = cmd_q;
                            tmr_d   = '0;
                            busy_d  = 1'b1;
                            start_o = 1'b1;
                        end
                        CMD_WRITE: begin
                            state_d = ST_WRITING;
                            cmd_d   = cmd_q;
                            tmr_d   = '0;
                            busy_d  = 1'b1;
                            start_o = 1'b1;
                        end
                        CMD_LOCK:  lock_set_o = 1'b1;
                        CMD_RWWRE: busy_d = 1'b0;
                        default:   ;
                    endcase
                end else if (load_req && lock_ptr && (cmd_q == CMD_LOCK) && !ee_busy) begin
                    lock_rd_o = 1'b1;
                    state_d   = ST_IDLE;
                    cmd_d     = '0;
                end else if (csr_take) begin
                    irq_en_d = csr_wdata[CSR_IRQEN];
                    if (csr_wdata[CSR_EN]) begin
                        cmd_d = csr_wdata[CSR_CMD0 +: 4];
                        cnt_d = '0;
                    end else begin
                        state_d = ST_IDLE;
                        cmd_d   = '0;
                    end
                end else if (cnt_q == WIN_LAST) begin
                    state_d = ST_IDLE;
                    cmd_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_ERASING, ST_WRITING: begin
                if (tmr_q == OP_LAST) begin
                    commit_erase_o = (state_q == ST_ERASING);
                    commit_write_o = (state_q == ST_WRITING);
                    state_d        = ST_IDLE;
                    cmd_d          = '0;
                end else begin
                    tmr_d = tmr_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o    = state_q;
    assign cmd_o      = cmd_q;
    assign irq_en_o   = irq_en_q;
    assign rww_busy_o = busy_q;

endmodule

// File: rtl/fsp_array.sv
module fsp_array
    import fsp_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int DEPTH      = 64,
    parameter int PAGE_WORDS = 8,
    parameter int RWW_WORDS  = 48,
    localparam int ADDR_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              commit_erase,
    input  logic              commit_write,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              lock_set,
    input  logic              load_req,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              lock_rd,
    input  logic              rww_busy,
    output logic [DATA_W-1:0] load_data,
    output logic              load_vld,
    output logic              viol,
    output logic [LOCK_W-1:0] lock_o
);

    localparam int PG_SH = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 0;
    localparam logic [DATA_W-1:0] BLOCKED = {(DATA_W/2){2'b10}};
    localparam logic [ADDR_W:0]   RWW_LIM = (ADDR_W+1)'(RWW_WORDS);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [LOCK_W-1:0] lock_q;
    logic              in_rww;

    assign in_rww = ({1'b0, load_addr} < RWW_LIM);

    // Flash stub: erase/write commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (commit_erase && ((ADDR_W'(i) >> PG_SH) == (addr_q >> PG_SH)))
                    mem[i] <= '1;
                else if (commit_write && (ADDR_W'(i) == addr_q))
                    mem[i] <= data_q;
            end
        end
    end

    // Operand capture and lock bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            lock_q <= '1;
        end else begin
            if (start) begin
                addr_q <= prog_addr;
                data_q <= prog_data;
            end
            if (lock_set) lock_q <= lock_q & prog_data[LOCK_W-1:0];
        end
    end

    // Load path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_data <= '0;
            load_vld  <= 1'b0;
            viol      <= 1'b0;
        end else begin
            load_vld <= load_req;
            if (load_req) begin
                if (lock_rd) begin
                    load_data <= DATA_W'({2'b11, lock_q});
                end else if (rww_busy && in_rww) begin
                    load_data <= BLOCKED;
                    viol      <= 1'b1;
                end else begin
                    load_data <= mem[load_addr];
                end
            end
        end
    end

    assign lock_o = lock_q;

endmodule

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
    import fsp_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int DEPTH      = 64,
    parameter int PAGE_WORDS = 8,
    parameter int RWW_WORDS  = 48,
    parameter int WINDOW     = 4,
    parameter int OP_CYCLES  = 6,
    localparam int ADDR_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [7:0]        csr_wdata,
    output logic [7:0]        csr_rdata,
    input  logic              prog_strobe,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              load_req,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [DATA_W-1:0] load_data,
    output logic              load_vld,
    input  logic              ee_busy,
    output logic              irq,
    output logic              viol
);

    fsp_state_e        state;
    logic [3:0]        cmd;
    logic              irq_en, rww_busy, enable;
    logic              start, commit_erase, commit_write, lock_set, lock_rd;
    logic              lock_ptr;
    logic [LOCK_W-1:0] lock_bits;

    assign lock_ptr = (load_addr == ADDR_W'(1));
    assign enable   = (state != ST_IDLE);

    fsp_fsm #(
        .WINDOW    (WINDOW),
        .OP_CYCLES (OP_CYCLES)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .csr_wr         (csr_wr),
        .csr_wdata      (csr_wdata),
        .prog_strobe    (prog_strobe),
        .load_req       (load_req),
        .lock_ptr       (lock_ptr),
        .ee_busy        (ee_busy),
        .state_o        (state),
        .cmd_o          (cmd),
        .irq_en_o       (irq_en),
        .rww_busy_o     (rww_busy),
        .start_o        (start),
        .commit_erase_o (commit_erase),
        .commit_write_o (commit_write),
        .lock_set_o     (lock_set),
        .lock_rd_o      (lock_rd)
    );

    fsp_array #(
        .DATA_W     (DATA_W),
        .DEPTH      (DEPTH),
        .PAGE_WORDS (PAGE_WORDS),
        .RWW_WORDS  (RWW_WORDS)
    ) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .commit_erase (commit_erase),
        .commit_write (commit_write),
        .prog_addr    (prog_addr),
        .prog_data    (prog_data),
        .lock_set     (lock_set),
        .load_req     (load_req),
        .load_addr    (load_addr),
        .lock_rd      (lock_rd),
        .rww_busy     (rww_busy),
        .load_data    (load_data),
        .load_vld     (load_vld),
        .viol         (viol),
        .lock_o       (lock_bits)
    );

    assign csr_rdata = {irq_en, rww_busy, 1'b0, cmd, enable};
    assign irq       = irq_en && !enable;

endmodule

// File: rtl/fsp_ctrl_chk.sv
module fsp_ctrl_chk
    import fsp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              csr_wr,
    input logic              ee_busy,
    input logic              prog_strobe,
    input logic [7:0]        csr_rdata,
    input logic              irq,
    input logic              viol,
    input fsp_state_e        state,
    input logic [LOCK_W-1:0] lock_bits
);

    // R6
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (csr_rdata[CSR_IRQEN] && !csr_rdata[CSR_EN]));

    // R4
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(csr_rdata[CSR_BUSY]) |-> ($past(prog_strobe) && $past(csr_rdata[4])));

    // R4
    busy_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASING || state == ST_WRITING) |-> csr_rdata[CSR_BUSY]);

    // R10
    ee_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_busy && csr_wr && !csr_rdata[CSR_EN]) |=> $stable(csr_rdata));

    // R8
    lock_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_bits & ~$past(lock_bits)) == '0);

    // R5
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(viol) |-> viol);

endmodule

bind fsp_ctrl fsp_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_wr      (csr_wr),
    .ee_busy     (ee_busy),
    .prog_strobe (prog_strobe),
    .csr_rdata   (csr_rdata),
    .irq         (irq),
    .viol        (viol),
    .state       (state),
    .lock_bits   (lock_bits)
);

// File: tb/fsp_ctrl_bench.sv
`timescale 1ns/1ps
module fsp_ctrl_bench;

    localparam int DW  = 16;
    localparam int DEP = 64;
    localparam int AW  = 6;
    localparam int PGW = 8;
    localparam int RWW = 48;
    localparam int WIN = 4;
    localparam int OPC = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_wr = 1'b0;
    logic [7:0]    csr_wdata = '0;
    logic [7:0]    csr_rdata;
    logic          prog_strobe = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [DW-1:0] prog_data = '0;
    logic          load_req = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [DW-1:0] load_data;
    logic          load_vld;
    logic          ee_busy = 1'b0;
    logic          irq;
    logic          viol;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_mem [DEP];
    logic [5:0]    exp_lock = 6'h3F;
    logic [DW-1:0] rd;

    always #2.5 clk = ~clk;

    fsp_ctrl u_fsp_ctrl (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .prog_strobe(prog_strobe), .prog_addr(prog_addr),
        .prog_data(prog_data), .load_req(load_req), .load_addr(load_addr),
        .load_data(load_data), .load_vld(load_vld), .ee_busy(ee_busy),
        .irq(irq), .viol(viol)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic csr_write(input logic [7:0] v);
        csr_wr = 1'b1; csr_wdata = v;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic strobe(input logic [AW-1:0] a, input logic [DW-1:0] d);
        prog_strobe = 1'b1; prog_addr = a; prog_data = d;
        @(negedge clk);
        prog_strobe = 1'b0;
    endtask

    task automatic load(input logic [AW-1:0] a, output logic [DW-1:0] d);
        load_req = 1'b1; load_addr = a;
        @(negedge clk);
        load_req = 1'b0;
        d = load_data;
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < DEP; i++) begin
            load(AW'(i), rd);
            check(req, rd, exp_mem[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        for (int i = 0; i < DEP; i++) exp_mem[i] = '1;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R2: reset state
        check("R2 reset csr", csr_rdata, 8'h00);
        check("R6 reset irq", irq, 1'b0);
        check("R5 reset viol", viol, 1'b0);

        // R9: lock byte read out of reset
        csr_write(8'h09);
        load(AW'(1), rd);
        check("R9 lock read reset", rd, 16'h00FF);
        check("R9 arming ended", csr_rdata[0], 1'b0);

        // R6: level interrupt
        csr_write(8'h80);
        for (int k = 0; k < 3; k++) begin
            check("R6 irq level", irq, 1'b1);
            idle(1);
        end
        csr_write(8'h00);
        check("R6 irq off", irq, 1'b0);

        // R1/R3/R4: window sweep over strobe delay
        for (int d = 1; d <= WIN + 2; d++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] v;
            a = AW'(d * 3);
            v = DW'(16'h1000 + d * 17);
            csr_write(8'h05);
            idle(d - 1);
            strobe(a, v);
            if (d <= WIN) begin
                check("R1 accepted enable", csr_rdata[0], 1'b1);
                check("R4 busy at dispatch", csr_rdata[6], 1'b1);
                idle(OPC - 1);
                check("R3 still running", csr_rdata[0], 1'b1);
                idle(1);
                check("R3 done enable", csr_rdata[0], 1'b0);
                check("R4 busy held", csr_rdata[6], 1'b1);
                exp_mem[a] = v;
                csr_write(8'h11);
                strobe('0, '0);
                check("R4 busy cleared", csr_rdata[6], 1'b0);
            end else begin
                check("R1 window lapsed", csr_rdata, 8'h00);
            end
        end
        sweep("R3 after writes");

        // R3/R5/R6: erase page 0 with interrupt enabled
        csr_write(8'h83);
        check("R6 irq low while armed", irq, 1'b0);
        strobe(AW'(5), '0);
        check("R4 busy erase", csr_rdata[6], 1'b1);
        load(AW'(10), rd);
        check("R5 blocked fill", rd, 16'hAAAA);
        check("R5 viol set", viol, 1'b1);
        load(AW'(50), rd);
        check("R5 upper readable", rd, exp_mem[50]);
        idle(OPC);
        check("R6 irq at completion", irq, 1'b1);
        load(AW'(9), rd);
        check("R4 still blocked", rd, 16'hAAAA);
        csr_write(8'h91);
        strobe('0, '0);
        check("R4 reenable", csr_rdata[6], 1'b0);
        check("R6 irq after reenable", irq, 1'b1);
        for (int i = 0; i < PGW; i++) exp_mem[i] = '1;
        sweep("R3 after erase");
        check("R5 viol sticky", viol, 1'b1);
        csr_write(8'h00);

        // R7/R8: lock mask sequence
        for (int k = 0; k < 4; k++) begin
            logic [7:0] m;
            m = (k < 3) ? (8'hC0 | (6'h3F & ~(6'h01 << k))) : 8'hFF;
            csr_write(8'h89);
            strobe('0, DW'(m));
            exp_lock = exp_lock & m[5:0];
            check("R7 no busy", csr_rdata[6], 1'b0);
            check("R7 done at once", csr_rdata[0], 1'b0);
            load(AW'(20), rd);
            check("R7 flash readable", rd, exp_mem[20]);
            csr_write(8'h09);
            load(AW'(1), rd);
            check("R8 lock value", rd, DW'({2'b11, exp_lock}));
        end
        csr_write(8'h00);

        // R9: armed load from another address
        csr_write(8'h09);
        load(AW'(2), rd);
        check("R9 other addr", rd, exp_mem[2]);
        check("R9 still armed", csr_rdata[0], 1'b1);
        idle(WIN);
        check("R1 lapsed after load", csr_rdata[0], 1'b0);

        // R10: EEPROM busy lockout
        ee_busy = 1'b1;
        csr_write(8'h05);
        check("R10 write ignored", csr_rdata, 8'h00);
        strobe(AW'(30), 16'h1234);
        idle(OPC + 1);
        ee_busy = 1'b0;
        load(AW'(30), rd);
        check("R10 no write", rd, exp_mem[30]);
        csr_write(8'h05);
        ee_busy = 1'b1;
        strobe(AW'(31), 16'h4321);
        check("R10 strobe masked", csr_rdata[6], 1'b0);
        ee_busy = 1'b0;
        idle(WIN);
        csr_write(8'h09);
        ee_busy = 1'b1;
        load(AW'(1), rd);
        check("R10 lock read refused", rd, exp_mem[1]);
        ee_busy = 1'b0;
        idle(WIN);
        load(AW'(31), rd);
        check("R10 no write 31", rd, exp_mem[31]);

        // R11/R2: invalid command combination
        csr_write(8'h07);
        check("R2 readback", csr_rdata, 8'h07);
        strobe(AW'(40), 16'h5555);
        check("R11 discarded", csr_rdata, 8'h00);
        idle(OPC + 1);
        load(AW'(40), rd);
        check("R11 no change", rd, exp_mem[40]);

        report();
    end

endmodule